// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block watches the command bus of a four-bank single-data-rate SDRAM and reports protocol violations. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable lines into a command. It tracks whether each bank is open, closed or still recovering from an automatic close. It also tracks whether a read or write burst is running and whether the mode register was written recently. Each class of rule has its own error output, which pulses for one cycle after the offending edge. A sticky summary flag collects all of them until software-independent logic clears it.

The monitor is passive. It sits beside a memory controller in simulation or in silicon and never drives the bus. A command that breaks a rule is reported and is then treated as if it had not happened, so the tracked state keeps following the legal command stream. The burst length is taken from an input at each read or write. The row-precharge recovery time is a parameter.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n} as 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode-register write, 0110 burst stop; 0111 or cs_n high is NOP. A command is accepted only if cke_i was high at the previous edge. Commands at an edge that follows one with cke_i low are ignored.
- R2: A mode-register write while any bank is open or recovering raises err_mrs_state_o.
- R3: Any accepted non-NOP command at either of the two edges after a legal mode-register write raises err_mrs_wait_o. No other check is applied to that command.
- R4: A refresh raises err_refresh_o unless every bank is closed and not recovering. This applies to an auto refresh with cke_i high and to a self-refresh entry with cke_i low.
- R5: Bank select is ba_i (0 to 3). Activating an open bank raises err_bank_state_o. A read or write to a bank that is not open also raises it, unless R7 applies.
- R6: A precharge with ap_i high closes all banks and ignores ba_i. With ap_i low it closes only the addressed bank.
- R7: A read or write with ap_i high at edge N and burst length L locks out reads and writes at edges N+1 to N+L-1. Such a command raises err_ap_lock_o. Reads and writes to any bank are legal again from edge N+L.
- R8: The bank of an auto-precharge burst closes when the burst ends. An activate to it before edge N+L+TRP raises err_trp_o.
- R9: A burst stop at edge S during a burst ends the burst. With auto precharge, reads and writes are legal from S+1 and the bank's activate is legal from S+1+TRP.
- R10: A flagged command changes no tracked state. Each error output is high only in the cycle after the offending edge.
- R11: err_any_o sets with any error and stays set until clr_i is sampled high with no new error at the same edge.
- R12: After reset all banks are closed and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Clears the sticky summary flag |
| cke_i | input | 1 | Clock enable of the memory |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | BANK_W (2) | Bank select |
| ap_i | input | 1 | Auto-precharge / all-bank address bit |
| burst_len_i | input | BL_W (4) | Burst length in beats, sampled at read/write |
| err_mrs_state_o | output | 1 | Mode-register write with a bank not idle |
| err_mrs_wait_o | output | 1 | Command inside the mode-register recovery gap |
| err_refresh_o | output | 1 | Refresh with a bank not idle |
| err_bank_state_o | output | 1 | Activate to open bank, or read/write to a bank that is not open |
| err_ap_lock_o | output | 1 | Read/write during an auto-precharge burst |
| err_trp_o | output | 1 | Activate before row-precharge recovery ends |
| err_any_o | output | 1 | Sticky summary of all errors |

## Verification
The assertions check these rules on every cycle. A bank is never open while its recovery counter runs. The bank tracker is never told to activate an open or recovering bank. No burst starts while the auto-precharge lockout is set. A burst stop empties the burst counter. Each mode-register or refresh error traces back to a command of that type. The sticky flag never drops without a clear. The exact edge windows need the bench's command sequences to show them: lockout up to N+L-1, activate legality at N+L+TRP, the two-edge gap after a mode-register write, and the ignored command after a clock-enable low. The same holds for burst length one, for a stop cutting a burst short, and for precharge of all banks versus one bank.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_MRS,
        CMD_BST
    } cmd_e;

    // error vector bit positions
    localparam int ERR_N     = 6;
    localparam int E_MRS_ST  = 5;
    localparam int E_MRS_GAP = 4;
    localparam int E_REF     = 3;
    localparam int E_BANK    = 2;
    localparam int E_LOCK    = 1;
    localparam int E_TRP     = 0;

    // idle edges required after a mode-register write
    localparam int MRS_GAP   = 2;

endpackage

// File: rtl/sdram_mon_decode.sv
module sdram_mon_decode
    import sdram_mon_pkg::*;
(
    input  logic cs_n_i,
    input  logic ras_n_i,
    input  logic cas_n_i,
    input  logic we_n_i,
    output cmd_e cmd_o
);

    // R1: strobe pattern to command
    always_comb begin
        cmd_o = CMD_NOP;
        if (!cs_n_i) begin
            case ({ras_n_i, cas_n_i, we_n_i})
                3'b011:  cmd_o = CMD_ACT;
                3'b101:  cmd_o = CMD_RD;
                3'b100:  cmd_o = CMD_WR;
                3'b010:  cmd_o = CMD_PRE;
                3'b001:  cmd_o = CMD_REF;
                3'b000:  cmd_o = CMD_MRS;
                3'b110:  cmd_o = CMD_BST;
                default: cmd_o = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_mon_banks.sv
module sdram_mon_banks #(
    parameter int NUM_BANKS = 4,
    parameter int TRP       = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] act_i,
    input  logic [NUM_BANKS-1:0] pre_i,
    input  logic [NUM_BANKS-1:0] close_i,
    output logic [NUM_BANKS-1:0] active_o,
    output logic [NUM_BANKS-1:0] recov_o
);

    localparam int TRP_W = $clog2(TRP + 1);

    typedef struct packed {
        logic             open;
        logic [TRP_W-1:0] trp;
    } bank_st_t;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_st_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (st_q.trp != '0) begin
                st_d.trp = st_q.trp - 1'b1;
            end
            if (pre_i[b]) begin
                st_d.open = 1'b0;
            end
            if (close_i[b]) begin
                st_d.open = 1'b0;
                st_d.trp  = TRP_W'(TRP);
            end
            if (act_i[b]) begin
                st_d.open = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign active_o[b] = st_q.open;
        assign recov_o[b]  = (st_q.trp != '0);

        // R8: a recovering bank is never open
        a_r8_closed_in_recovery : assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.trp != '0) |-> !st_q.open);
        // R5: activate is only applied to a closed bank
        a_r5_no_double_open : assert property (@(posedge clk) disable iff (!rst_n)
            act_i[b] |-> !st_q.open);
        // R8: activate is never applied during recovery
        a_r8_no_act_in_recovery : assert property (@(posedge clk) disable iff (!rst_n)
            act_i[b] |-> (st_q.trp == '0));
    end

endmodule

// File: rtl/sdram_mon_burst.sv
module sdram_mon_burst #(
    parameter int BANK_W = 2,
    parameter int BL_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              start_ap_i,
    input  logic [BANK_W-1:0] start_bank_i,
    input  logic [BL_W-1:0]   len_i,
    input  logic              stop_i,
    output logic              lock_o,
    output logic              close_o,
    output logic [BANK_W-1:0] close_bank_o
);

    typedef struct packed {
        logic [BL_W-1:0]   cnt;
        logic              ap;
        logic [BANK_W-1:0] bank;
    } burst_st_t;

    burst_st_t st_d, st_q;
    logic      busy;
    logic      short_ap;

    assign busy     = (st_q.cnt != '0);
    assign short_ap = start_i && start_ap_i && (len_i <= BL_W'(1));

    always_comb begin
        st_d = st_q;
        if (busy) begin
            st_d.cnt = stop_i ? '0 : st_q.cnt - 1'b1;
        end
        if (start_i) begin
            st_d.cnt  = (len_i == '0) ? '0 : len_i - 1'b1;
            st_d.ap   = start_ap_i;
            st_d.bank = start_bank_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: lockout while an auto-precharge burst runs
    assign lock_o       = busy && st_q.ap;
    // R8/R9: bank closes on the last beat, on a stop, or at once for length one
    assign close_o      = (lock_o && ((st_q.cnt == BL_W'(1)) || stop_i)) || short_ap;
    assign close_bank_o = start_i ? start_bank_i : st_q.bank;

    a_r7_no_start_in_lock : assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !lock_o);
    a_r9_stop_ends_burst : assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && busy) |=> (st_q.cnt == '0));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int BL_W   = 4,
    parameter int TRP    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              cke_i,
    input  logic              cs_n_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic [BANK_W-1:0] ba_i,
    input  logic              ap_i,
    input  logic [BL_W-1:0]   burst_len_i,
    output logic              err_mrs_state_o,
    output logic              err_mrs_wait_o,
    output logic              err_refresh_o,
    output logic              err_bank_state_o,
    output logic              err_ap_lock_o,
    output logic              err_trp_o,
    output logic              err_any_o
);

    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int MRS_W     = $clog2(MRS_GAP + 1);

    typedef struct packed {
        logic             cke;
        logic [MRS_W-1:0] mrs_cnt;
        logic [ERR_N-1:0] err;
        logic             sticky;
    } mon_st_t;

    mon_st_t st_d, st_q;

    cmd_e                  cmd;
    logic [NUM_BANKS-1:0]  active, recov;
    logic [NUM_BANKS-1:0]  act_v, pre_v, close_v, sel_oh;
    logic                  lock, close_p;
    logic [BANK_W-1:0]     close_bank;
    logic                  valid, chk, in_gap, all_idle, is_rw;
    logic                  bank_open, bank_recov;
    logic                  rw_ok, stop_ok;

    sdram_mon_decode u_decode (
        .cs_n_i  (cs_n_i),
        .ras_n_i (ras_n_i),
        .cas_n_i (cas_n_i),
        .we_n_i  (we_n_i),
        .cmd_o   (cmd)
    );

    sdram_mon_banks #(
        .NUM_BANKS (NUM_BANKS),
        .TRP       (TRP)
    ) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_i    (act_v),
        .pre_i    (pre_v),
        .close_i  (close_v),
        .active_o (active),
        .recov_o  (recov)
    );

    sdram_mon_burst #(
        .BANK_W (BANK_W),
        .BL_W   (BL_W)
    ) u_burst (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (rw_ok),
        .start_ap_i   (ap_i),
        .start_bank_i (ba_i),
        .len_i        (burst_len_i),
        .stop_i       (stop_ok),
        .lock_o       (lock),
        .close_o      (close_p),
        .close_bank_o (close_bank)
    );

    assign sel_oh     = NUM_BANKS'(1) << ba_i;
    assign bank_open  = active[ba_i];
    assign bank_recov = recov[ba_i];
    assign all_idle   = (active == '0) && (recov == '0);
    assign is_rw      = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign valid      = st_q.cke && (cmd != CMD_NOP);          // R1
    assign in_gap     = (st_q.mrs_cnt != '0);
    assign chk        = valid && !in_gap;

    assign rw_ok      = chk && is_rw && !lock && bank_open;
    assign stop_ok    = chk && (cmd == CMD_BST);
    assign act_v      = (chk && (cmd == CMD_ACT) && !bank_open && !bank_recov) ? sel_oh : '0;
    // R6: all banks with ap high, addressed bank otherwise
    assign pre_v      = (chk && (cmd == CMD_PRE)) ? (ap_i ? '1 : sel_oh) : '0;
    assign close_v    = close_p ? (NUM_BANKS'(1) << close_bank) : '0;

    always_comb begin
        st_d     = st_q;
        st_d.cke = cke_i;
        st_d.err = '0;

        st_d.err[E_MRS_GAP] = valid && in_gap;                                   // R3
        st_d.err[E_MRS_ST]  = chk && (cmd == CMD_MRS) && !all_idle;              // R2
        st_d.err[E_REF]     = chk && (cmd == CMD_REF) && !all_idle;              // R4
        st_d.err[E_LOCK]    = chk && is_rw && lock;                              // R7
        st_d.err[E_BANK]    = chk && (((cmd == CMD_ACT) && bank_open) ||
                                      (is_rw && !lock && !bank_open));           // R5
        st_d.err[E_TRP]     = chk && (cmd == CMD_ACT) && !bank_open && bank_recov; // R8

        if (in_gap) begin
            st_d.mrs_cnt = st_q.mrs_cnt - 1'b1;
        end
        if (chk && (cmd == CMD_MRS) && all_idle) begin
            st_d.mrs_cnt = MRS_W'(MRS_GAP);
        end

        // R11: a new error wins over a clear at the same edge
        st_d.sticky = (st_q.sticky && !clr_i) || (st_d.err != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cke <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_mrs_state_o  = st_q.err[E_MRS_ST];
    assign err_mrs_wait_o   = st_q.err[E_MRS_GAP];
    assign err_refresh_o    = st_q.err[E_REF];
    assign err_bank_state_o = st_q.err[E_BANK];
    assign err_ap_lock_o    = st_q.err[E_LOCK];
    assign err_trp_o        = st_q.err[E_TRP];
    assign err_any_o        = st_q.sticky;

    a_r2_mrs_origin : assert property (@(posedge clk) disable iff (!rst_n)
        err_mrs_state_o |-> $past(cmd == CMD_MRS));
    a_r3_gap_origin : assert property (@(posedge clk) disable iff (!rst_n)
        err_mrs_wait_o |-> $past(cmd != CMD_NOP));
    a_r4_ref_origin : assert property (@(posedge clk) disable iff (!rst_n)
        err_refresh_o |-> $past(cmd == CMD_REF));
    a_r11_sticky_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (err_any_o && !clr_i) |=> err_any_o);
    a_r11_sticky_covers : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err != '0) |-> err_any_o);
    a_r10_one_class_gap : assert property (@(posedge clk) disable iff (!rst_n)
        err_mrs_wait_o |-> ($countones(st_q.err) == 1));

endmodule

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_i = 1'b0;
    logic       cke_i = 1'b1;
    logic       cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
    logic [1:0] ba_i = '0;
    logic       ap_i = 1'b0;
    logic [3:0] burst_len_i = 4'd4;
    logic       e_mst, e_gap, e_ref, e_bank, e_lock, e_trp, e_any;

    int checks = 0;
    int bad    = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sdram_cmd_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .cke_i(cke_i),
        .cs_n_i(cs_n_i), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
        .ba_i(ba_i), .ap_i(ap_i), .burst_len_i(burst_len_i),
        .err_mrs_state_o(e_mst), .err_mrs_wait_o(e_gap), .err_refresh_o(e_ref),
        .err_bank_state_o(e_bank), .err_ap_lock_o(e_lock), .err_trp_o(e_trp),
        .err_any_o(e_any)
    );

    // command codes {cs,ras,cas,we}
    localparam logic [3:0] MRS = 4'h0, REF = 4'h1, PRE = 4'h2, ACT = 4'h3;
    localparam logic [3:0] WR  = 4'h4, RD  = 4'h5, BST = 4'h6, NOP = 4'h7;

    // {code[13:10], cke[9], ba[8:7], ap[6], expected {mst,gap,ref,bank,lock,trp}[5:0]}
    localparam int NV = 41;
    localparam logic [13:0] VEC [NV] = '{
        {MRS,1'b1,2'd0,1'b0,6'b000000}, // 0  R2 legal
        {NOP,1'b1,2'd0,1'b0,6'b000000}, // 1
        {ACT,1'b1,2'd0,1'b0,6'b010000}, // 2  R3 gap
        {ACT,1'b1,2'd0,1'b0,6'b000000}, // 3  R10 gap command not applied
        {ACT,1'b1,2'd0,1'b0,6'b000100}, // 4  R5 open bank
        {MRS,1'b1,2'd0,1'b0,6'b100000}, // 5  R2
        {REF,1'b1,2'd0,1'b0,6'b001000}, // 6  R4
        {RD ,1'b1,2'd1,1'b0,6'b000100}, // 7  R5 closed bank
        {RD ,1'b1,2'd0,1'b1,6'b000000}, // 8  AP burst N=8, L=4
        {WR ,1'b1,2'd0,1'b0,6'b000010}, // 9  R7
        {NOP,1'b1,2'd0,1'b0,6'b000000}, // 10
        {RD ,1'b1,2'd2,1'b0,6'b000010}, // 11 R7 last locked edge
        {ACT,1'b1,2'd0,1'b0,6'b000001}, // 12 R8
        {NOP,1'b1,2'd0,1'b0,6'b000000}, // 13
        {ACT,1'b1,2'd0,1'b0,6'b000001}, // 14 R8 edge N+L+TRP-1
        {ACT,1'b1,2'd0,1'b0,6'b000000}, // 15 R8 first legal
        {WR ,1'b1,2'd0,1'b0,6'b000000}, // 16 plain burst
        {WR ,1'b1,2'd0,1'b0,6'b000000}, // 17 no lockout without AP
        {PRE,1'b1,2'd2,1'b1,6'b000000}, // 18 R6 all banks
        {REF,1'b1,2'd0,1'b0,6'b000000}, // 19 R4 legal
        {ACT,1'b1,2'd3,1'b0,6'b000000}, // 20
        {RD ,1'b1,2'd3,1'b1,6'b000000}, // 21 AP burst
        {BST,1'b1,2'd0,1'b0,6'b000000}, // 22 R9 stop
        {RD ,1'b1,2'd3,1'b0,6'b000100}, // 23 R9 no lock, bank closed
        {ACT,1'b1,2'd3,1'b0,6'b000001}, // 24 R9 recovery
        {NOP,1'b1,2'd0,1'b0,6'b000000}, // 25
        {ACT,1'b1,2'd3,1'b0,6'b000000}, // 26 R9 S+1+TRP
        {PRE,1'b1,2'd3,1'b0,6'b000000}, // 27 R6 single
        {MRS,1'b1,2'd0,1'b0,6'b000000}, // 28
        {NOP,1'b1,2'd0,1'b0,6'b000000}, // 29 R1 NOP allowed in gap
        {NOP,1'b1,2'd0,1'b0,6'b000000}, // 30
        {ACT,1'b1,2'd1,1'b0,6'b000000}, // 31 R3 gap over
        {PRE,1'b1,2'd1,1'b0,6'b000000}, // 32
        {REF,1'b0,2'd0,1'b0,6'b000000}, // 33 R4 self-refresh entry legal
        {ACT,1'b0,2'd2,1'b0,6'b000000}, // 34 R1 ignored
        {NOP,1'b1,2'd0,1'b0,6'b000000}, // 35
        {RD ,1'b1,2'd2,1'b0,6'b000100}, // 36 R1 bank 2 still closed
        {ACT,1'b1,2'd2,1'b0,6'b000000}, // 37
        {REF,1'b0,2'd0,1'b0,6'b001000}, // 38 R4 self-refresh with open bank
        {NOP,1'b1,2'd0,1'b0,6'b000000}, // 39
        {PRE,1'b1,2'd0,1'b1,6'b000000}  // 40
    };

    function automatic string tags(input logic [5:0] diff);
        string s = "";
        if (diff[5]) s = {s, "R2 "};
        if (diff[4]) s = {s, "R3 "};
        if (diff[3]) s = {s, "R4 "};
        if (diff[2]) s = {s, "R5 "};
        if (diff[1]) s = {s, "R7 "};
        if (diff[0]) s = {s, "R8 "};
        return s;
    endfunction

    task automatic check(input logic [6:0] got, input logic [6:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", what, got, exp);
        end
    endtask

    task automatic step(input logic [3:0] code, input logic cke, input logic [1:0] ba,
                        input logic ap, input logic [3:0] bl, input logic clr,
                        input logic [5:0] exp, input string what);
        logic [5:0] got;
        @(negedge clk);
        {cs_n_i, ras_n_i, cas_n_i, we_n_i} = code;
        cke_i = cke; ba_i = ba; ap_i = ap; burst_len_i = bl; clr_i = clr;
        @(posedge clk);
        #1;
        got = {e_mst, e_gap, e_ref, e_bank, e_lock, e_trp};
        check({1'b0, got}, {1'b0, exp}, (what == "") ? tags(got ^ exp) : what);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R12: reset state
        check({e_mst, e_gap, e_ref, e_bank, e_lock, e_trp, e_any}, 7'b0, "R12 reset outputs");

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][13:10], VEC[i][9], VEC[i][8:7], VEC[i][6], 4'd4, 1'b0,
                 VEC[i][5:0], $sformatf("table step %0d %s", i, tags(VEC[i][5:0])));
        end

        // R11: sticky set by earlier errors
        check({6'b0, e_any}, 7'b1, "R11 sticky after errors");

        // R7 R8: burst length one, no lockout, recovery from N+1
        step(ACT, 1'b1, 2'd0, 1'b0, 4'd4, 1'b0, 6'b000000, "R5 open bank 0");
        step(ACT, 1'b1, 2'd1, 1'b0, 4'd4, 1'b0, 6'b000000, "R5 open bank 1");
        step(RD,  1'b1, 2'd1, 1'b1, 4'd1, 1'b0, 6'b000000, "R7 length-one AP read");
        step(RD,  1'b1, 2'd0, 1'b0, 4'd1, 1'b0, 6'b000000, "R7 no lockout at length one");
        step(ACT, 1'b1, 2'd1, 1'b0, 4'd4, 1'b0, 6'b000001, "R8 recovery after length one");

        // R11: clear, then error together with clear
        step(NOP, 1'b1, 2'd0, 1'b0, 4'd4, 1'b1, 6'b000000, "R11 clear edge");
        check({6'b0, e_any}, 7'b0, "R11 sticky cleared");
        step(ACT, 1'b1, 2'd0, 1'b0, 4'd4, 1'b1, 6'b000100, "R5 activate open bank");
        check({6'b0, e_any}, 7'b1, "R11 error wins over clear");
        // R10: pulse lasts one cycle
        step(NOP, 1'b1, 2'd0, 1'b0, 4'd4, 1'b0, 6'b000000, "R10 error pulse ends");
        check({6'b0, e_any}, 7'b1, "R11 sticky holds");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule